// File: doc/BRIEF.md
# Serial OSD Command Interface

This block is the host-facing front end of an on-screen display engine. A host shifts 8-bit words into it over three wires: an active-low select, a serial clock and a data line. The block groups the bits into bytes and reads each byte as either a command or data. It keeps a current command, a display write pointer and six configuration words. It issues write strobes toward the character memory, and each strobe carries a row, a column, two attribute bits and a 7-bit character code.

Only the first byte of a transfer needs to name a command. That command stays in force for every data byte that follows, so the host can stream a run of character codes without sending a command byte before each one. Once a character-write command is accepted, the block locks into that mode. The lock holds until select is released, and releasing select also returns the block to pointer-setting mode.

A configuration command can also start a memory clear. The clear takes over the write port, writes the blank code to every cell and then holds a busy flag until a minimum time has passed. The serial pins are sampled on the block's own system clock, and the serial clock must run much slower than the system clock.

Top module: `osd_cmd_if`

## Requirements
- R1: A synchronous active-high reset clears the pointer, all configuration words and the attribute latch, sets the current command to pointer-set (0), clears the lock and the busy flag, and produces no write strobe.
- R2: Bits are taken MSB first on rising serial-clock edges, and only while select is low. While select is high the bit count restarts, so a partly shifted byte is discarded and any bits clocked during that time are ignored.
- R3: A byte with bit 7 set is a command byte: bits 6:4 give the command number and bits 3:0 its argument. A byte with bit 7 clear is a data byte. For command 0 the argument is the row, and each later data byte puts its bits 4:0 into the column.
- R4: Command 1 latches argument bit 1 as attribute A and argument bit 0 as attribute B. Each data byte then writes wr_data = {A, B, byte[6:0]} at the current row and column.
- R5: After command 1 is accepted, command bytes are ignored (no change to any register and no write) until select goes high.
- R6: While select is high, the current command becomes 0 and the lock clears. A data byte in the next transfer therefore sets the column.
- R7: Each character write advances the column by one. After column 23 the column goes to 0 and the row goes up by one, and after row 11, column 23 the pointer goes to row 0, column 0.
- R8: A row argument above 11 loads row 11, and a column value above 23 loads column 23.
- R9: Commands 2 to 7 each own a 10-bit configuration word (cfg_vpos, cfg_hpos, cfg_ctl1 to cfg_ctl4). The command byte's argument goes into bits 9:6. Every following data byte puts its bits 5:0 into bits 5:0 of the same word.
- R10: mode_eff[i] is the OR of mode_pin[i] and bit 6+i of cfg_ctl3.
- R11: A command-4 byte with argument bit 2 set starts a clear. The clear writes data 0x07F once to each of the 288 cells and holds clr_busy high for at least CLR_MIN_CYCLES cycles.
- R12: While clr_busy is high, character writes from the serial side are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, low to transfer |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdi | input | 1 | Serial data, MSB first |
| mode_pin | input | 4 | External video mode straps |
| wr_en | output | 1 | Character memory write strobe |
| wr_row | output | 4 | Write row |
| wr_col | output | 5 | Write column |
| wr_data | output | 9 | {attr A, attr B, code[6:0]} |
| addr_row | output | 4 | Current pointer row |
| addr_col | output | 5 | Current pointer column |
| cfg_vpos | output | 10 | Command 2 configuration word |
| cfg_hpos | output | 10 | Command 3 configuration word |
| cfg_ctl1 | output | 10 | Command 4 configuration word |
| cfg_ctl2 | output | 10 | Command 5 configuration word |
| cfg_ctl3 | output | 10 | Command 6 configuration word |
| cfg_ctl4 | output | 10 | Command 7 configuration word |
| mode_eff | output | 4 | Mode bits ORed with mode_pin |
| clr_busy | output | 1 | Memory clear in progress |

## Verification
The main function is driven with three kinds of byte stream: a command followed by several data bytes, a command byte inserted into a character-write run, and a data byte sent right after select is re-asserted. These separate a command that is held across bytes from one that must be repeated, show whether the lock holds, and show whether releasing select restores pointer-set mode. The pointer is driven to column 23 and to row 11, column 23 to test both wrap paths, and out-of-range row and column values test the clamp. A half-shifted byte cut off by select, a clear that overlaps a character write, and a mode strap ORed with the register bits cover the rest.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 10;
    localparam int N_CFG  = 6;
    localparam int ARG_W  = 4;
    localparam int CODE_W = 7;
    localparam int ATTR_W = 2;

    typedef enum logic [2:0] {
        CMD_ADDR = 3'd0,
        CMD_CHAR = 3'd1,
        CMD_VPOS = 3'd2,
        CMD_HPOS = 3'd3,
        CMD_CTL1 = 3'd4,
        CMD_CTL2 = 3'd5,
        CMD_CTL3 = 3'd6,
        CMD_CTL4 = 3'd7
    } cmd_e;

    typedef struct packed {
        logic             is_cmd;
        logic [2:0]       num;
        logic [ARG_W-1:0] arg;
    } ser_byte_t;

    typedef struct packed {
        logic [ATTR_W-1:0] attr;
        logic [CODE_W-1:0] code;
    } cell_t;

    localparam cell_t BLANK_CELL = '{attr: '0, code: 7'h7F};

    localparam int ERASE_ARG_BIT = 2;

    function automatic logic [2:0] cfg_index(input logic [2:0] num);
        return num - 3'd2;
    endfunction

endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
    import osd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rise;

    assign rise = sclk && !sclk_q && !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            sclk_q   <= sclk;
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[BYTE_W-2:0], sdi};
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {shreg[BYTE_W-2:0], sdi};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
    import osd_cmd_pkg::*;
#(
    parameter int ROWS  = 12,
    parameter int COLS  = 24,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        byte_vld,
    input  logic [BYTE_W-1:0]           byte_q,
    input  logic                        clr_busy,
    output cmd_e                        cur_cmd,
    output logic                        locked,
    output logic [ROW_W-1:0]            row,
    output logic [COL_W-1:0]            col,
    output logic                        wr_en,
    output logic [ROW_W-1:0]            wr_row,
    output logic [COL_W-1:0]            wr_col,
    output cell_t                       wr_cell,
    output logic [N_CFG-1:0][CFG_W-1:0] cfg,
    output logic                        clr_start
);
    ser_byte_t         b;
    logic [ATTR_W-1:0] attr;

    assign b = ser_byte_t'(byte_q);

    function automatic logic [ROW_W-1:0] clamp_row(input logic [ARG_W-1:0] v);
        return (int'(v) >= ROWS) ? ROW_W'(ROWS - 1) : ROW_W'(v);
    endfunction

    function automatic logic [COL_W-1:0] clamp_col(input logic [4:0] v);
        return (int'(v) >= COLS) ? COL_W'(COLS - 1) : COL_W'(v);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cmd   <= CMD_ADDR;
            locked    <= 1'b0;
            row       <= '0;
            col       <= '0;
            wr_en     <= 1'b0;
            wr_row    <= '0;
            wr_col    <= '0;
            wr_cell   <= '0;
            cfg       <= '0;
            attr      <= '0;
            clr_start <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            clr_start <= 1'b0;
            if (cs_n) begin
                cur_cmd <= CMD_ADDR;
                locked  <= 1'b0;
            end else if (byte_vld) begin
                if (b.is_cmd) begin
                    if (!locked) begin
                        cur_cmd <= cmd_e'(b.num);
                        case (cmd_e'(b.num))
                            CMD_ADDR: row <= clamp_row(b.arg);
                            CMD_CHAR: begin
                                locked <= 1'b1;
                                attr   <= b.arg[ATTR_W-1:0];
                            end
                            default: begin
                                cfg[cfg_index(b.num)][CFG_W-1:CFG_W-ARG_W] <= b.arg;
                                if (cmd_e'(b.num) == CMD_CTL1 && b.arg[ERASE_ARG_BIT] && !clr_busy)
                                    clr_start <= 1'b1;
                            end
                        endcase
                    end
                end else begin
                    case (cur_cmd)
                        CMD_ADDR: col <= clamp_col(byte_q[4:0]);
                        CMD_CHAR: begin
                            if (!clr_busy) begin
                                wr_en   <= 1'b1;
                                wr_row  <= row;
                                wr_col  <= col;
                                wr_cell <= '{attr: attr, code: byte_q[CODE_W-1:0]};
                                if (col == COL_W'(COLS - 1)) begin
                                    col <= '0;
                                    row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
                                end else begin
                                    col <= col + 1'b1;
                                end
                            end
                        end
                        default: cfg[cfg_index(cur_cmd)][CFG_W-ARG_W-1:0] <= byte_q[CFG_W-ARG_W-1:0];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/osd_ram_clear.sv
module osd_ram_clear #(
    parameter int ROWS           = 12,
    parameter int COLS           = 24,
    parameter int CLR_MIN_CYCLES = 13500,
    parameter int ROW_W          = $clog2(ROWS),
    parameter int COL_W          = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             wr_en,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam int CELLS = ROWS * COLS;
    localparam int TOTAL = (CLR_MIN_CYCLES > CELLS) ? CLR_MIN_CYCLES : CELLS;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0] cnt;

    assign wr_en = busy && (cnt < CNT_W'(CELLS));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            row  <= '0;
            col  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            row  <= '0;
            col  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(TOTAL - 1))
                busy <= 1'b0;
            if (wr_en) begin
                if (col == COL_W'(COLS - 1)) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_cmd_if.sv
module osd_cmd_if
    import osd_cmd_pkg::*;
#(
    parameter int ROWS           = 12,
    parameter int COLS           = 24,
    parameter int CLR_MIN_CYCLES = 13500,
    parameter int ROW_W          = $clog2(ROWS),
    parameter int COL_W          = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [3:0]       mode_pin,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [8:0]       wr_data,
    output logic [ROW_W-1:0] addr_row,
    output logic [COL_W-1:0] addr_col,
    output logic [9:0]       cfg_vpos,
    output logic [9:0]       cfg_hpos,
    output logic [9:0]       cfg_ctl1,
    output logic [9:0]       cfg_ctl2,
    output logic [9:0]       cfg_ctl3,
    output logic [9:0]       cfg_ctl4,
    output logic [3:0]       mode_eff,
    output logic             clr_busy
);
    logic                        byte_vld;
    logic [BYTE_W-1:0]           byte_q;
    cmd_e                        cur_cmd;
    logic                        locked;
    logic                        ser_wr;
    logic [ROW_W-1:0]            ser_row;
    logic [COL_W-1:0]            ser_col;
    cell_t                       ser_cell;
    logic [N_CFG-1:0][CFG_W-1:0] cfg;
    logic                        clr_start;
    logic                        clr_wr;
    logic [ROW_W-1:0]            clr_row;
    logic [COL_W-1:0]            clr_col;

    osd_ser_rx u_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .byte_vld(byte_vld), .byte_q(byte_q)
    );

    osd_cmd_fsm #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_q(byte_q),
        .clr_busy(clr_busy), .cur_cmd(cur_cmd), .locked(locked),
        .row(addr_row), .col(addr_col), .wr_en(ser_wr), .wr_row(ser_row),
        .wr_col(ser_col), .wr_cell(ser_cell), .cfg(cfg), .clr_start(clr_start)
    );

    osd_ram_clear #(.ROWS(ROWS), .COLS(COLS), .CLR_MIN_CYCLES(CLR_MIN_CYCLES),
                    .ROW_W(ROW_W), .COL_W(COL_W)) u_clr (
        .clk(clk), .rst(rst), .start(clr_start), .busy(clr_busy),
        .wr_en(clr_wr), .row(clr_row), .col(clr_col)
    );

    always_comb begin
        if (clr_busy) begin
            wr_en   = clr_wr;
            wr_row  = clr_row;
            wr_col  = clr_col;
            wr_data = BLANK_CELL;
        end else begin
            wr_en   = ser_wr;
            wr_row  = ser_row;
            wr_col  = ser_col;
            wr_data = ser_cell;
        end
    end

    assign cfg_vpos = cfg[0];
    assign cfg_hpos = cfg[1];
    assign cfg_ctl1 = cfg[2];
    assign cfg_ctl2 = cfg[3];
    assign cfg_ctl3 = cfg[4];
    assign cfg_ctl4 = cfg[5];
    assign mode_eff = cfg_ctl3[9:6] | mode_pin;
endmodule

// File: rtl/osd_cmd_if_chk.sv
module osd_cmd_if_chk
    import osd_cmd_pkg::*;
#(
    parameter int ROWS  = 12,
    parameter int COLS  = 24,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input cmd_e             cur_cmd,
    input logic             locked,
    input logic             wr_en,
    input logic [ROW_W-1:0] wr_row,
    input logic [COL_W-1:0] wr_col,
    input logic [8:0]       wr_data,
    input logic             clr_busy,
    input logic             ser_wr,
    input logic [ROW_W-1:0] ser_row,
    input logic [COL_W-1:0] ser_col,
    input logic [ROW_W-1:0] addr_row,
    input logic [COL_W-1:0] addr_col
);
    // R8: every write lands inside the display grid
    a_r8_wr_in_grid: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_row) < ROWS) && (int'(wr_col) < COLS));

    // R6: select high returns to pointer-set and clears the lock
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cur_cmd == CMD_ADDR) && !locked);

    // R5: once locked and select stays low, the command stays character-write
    a_r5_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (locked && !cs_n) |=> (cur_cmd == CMD_CHAR));

    // R11: clear writes carry the blank cell
    a_r11_blank_data: assert property (@(posedge clk) disable iff (rst)
        (clr_busy && wr_en) |-> (wr_data == 9'h07F));

    // R7: the pointer moves one step past each character write
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        ser_wr |-> ((addr_col == ser_col + 1'b1) && (addr_row == ser_row)) ||
                   ((addr_col == '0) && (int'(ser_col) == COLS - 1)));

    // R12: no serial character write is launched during a clear
    a_r12_no_ser_in_clear: assert property (@(posedge clk) disable iff (rst)
        clr_busy |=> !ser_wr);
endmodule

bind osd_cmd_if osd_cmd_if_chk #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cur_cmd(cur_cmd), .locked(locked),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .clr_busy(clr_busy), .ser_wr(ser_wr), .ser_row(ser_row), .ser_col(ser_col),
    .addr_row(addr_row), .addr_col(addr_col)
);

// File: tb/tb_osd_cmd_if.sv
module tb_osd_cmd_if;
    localparam int PERIOD  = 10;
    localparam int CLR_MIN = 13500;
    localparam int HALF    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [3:0] mode_pin = 4'd0;
    logic       wr_en;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [8:0] wr_data;
    logic [3:0] addr_row;
    logic [4:0] addr_col;
    logic [9:0] cfg_vpos, cfg_hpos, cfg_ctl1, cfg_ctl2, cfg_ctl3, cfg_ctl4;
    logic [3:0] mode_eff;
    logic       clr_busy;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int busy_cycles = 0;
    int clr_bad = 0;
    logic [3:0] last_row;
    logic [4:0] last_col;
    logic [8:0] last_data;

    always #(PERIOD/2) clk = ~clk;

    osd_cmd_if #(.CLR_MIN_CYCLES(CLR_MIN)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .mode_pin(mode_pin),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .addr_row(addr_row), .addr_col(addr_col), .cfg_vpos(cfg_vpos), .cfg_hpos(cfg_hpos),
        .cfg_ctl1(cfg_ctl1), .cfg_ctl2(cfg_ctl2), .cfg_ctl3(cfg_ctl3), .cfg_ctl4(cfg_ctl4),
        .mode_eff(mode_eff), .clr_busy(clr_busy)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                wr_cnt++;
                last_row  = wr_row;
                last_col  = wr_col;
                last_data = wr_data;
                if (clr_busy && wr_data != 9'h07F) clr_bad++;
            end
            if (clr_busy) busy_cycles++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = v[i];
            ticks(HALF);
            sclk = 1'b1;
            ticks(HALF);
            sclk = 1'b0;
        end
        ticks(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        send_bits(v, 8);
    endtask

    task automatic sel_lo();
        cs_n = 1'b0;
        ticks(4);
    endtask

    task automatic sel_hi();
        ticks(4);
        cs_n = 1'b1;
        ticks(4);
    endtask

    task automatic t_reset();
        chk(addr_row == 0 && addr_col == 0, "R1 pointer", {addr_row, addr_col}, 0);
        chk(cfg_vpos == 0 && cfg_ctl1 == 0 && cfg_ctl3 == 0, "R1 cfg", cfg_vpos, 0);
        chk(wr_cnt == 0 && !clr_busy, "R1 idle", wr_cnt, 0);
    endtask

    task automatic t_addr();
        sel_lo();
        send_byte(8'h83);
        send_byte(8'h05);
        chk(addr_row == 3, "R3 row", addr_row, 3);
        chk(addr_col == 5, "R3 col", addr_col, 5);
    endtask

    task automatic t_char();
        int base = wr_cnt;
        send_byte(8'h93);
        send_byte(8'h41);
        chk(last_row == 3 && last_col == 5 && last_data == 9'h1C1, "R4 first write",
            {last_row, last_col, last_data}, {4'd3, 5'd5, 9'h1C1});
        send_byte(8'h42);
        chk(wr_cnt - base == 2, "R4 count", wr_cnt - base, 2);
        chk(last_col == 6 && last_data == 9'h1C2, "R4 second write", {last_col, last_data}, {5'd6, 9'h1C2});
        chk(addr_col == 7, "R7 advance", addr_col, 7);
    endtask

    task automatic t_lock();
        int base = wr_cnt;
        send_byte(8'hA5);
        chk(cfg_vpos == 0 && wr_cnt == base, "R5 cmd ignored", cfg_vpos, 0);
        send_byte(8'h43);
        chk(last_col == 7 && last_data == 9'h1C3 && wr_cnt == base + 1, "R5 still writing",
            {last_col, last_data}, {5'd7, 9'h1C3});
    endtask

    task automatic t_release();
        int base = wr_cnt;
        sel_hi();
        sel_lo();
        send_byte(8'h0A);
        chk(addr_col == 10 && addr_row == 3, "R6 data sets column", {addr_row, addr_col}, {4'd3, 5'd10});
        chk(wr_cnt == base, "R6 no write", wr_cnt - base, 0);
    endtask

    task automatic t_wrap();
        send_byte(8'h82);
        send_byte(8'h17);
        send_byte(8'h90);
        send_byte(8'h01);
        chk(last_row == 2 && last_col == 23 && last_data == 9'h001, "R7 edge write",
            {last_row, last_col}, {4'd2, 5'd23});
        chk(addr_row == 3 && addr_col == 0, "R7 row wrap", {addr_row, addr_col}, {4'd3, 5'd0});
        sel_hi();
        sel_lo();
        send_byte(8'h8B);
        send_byte(8'h17);
        send_byte(8'h90);
        send_byte(8'h02);
        chk(addr_row == 0 && addr_col == 0, "R7 grid wrap", {addr_row, addr_col}, 0);
        sel_hi();
    endtask

    task automatic t_clamp();
        sel_lo();
        send_byte(8'h8E);
        send_byte(8'h1F);
        chk(addr_row == 11 && addr_col == 23, "R8 clamp", {addr_row, addr_col}, {4'd11, 5'd23});
    endtask

    task automatic t_cfg();
        send_byte(8'hA6);
        send_byte(8'h2A);
        chk(cfg_vpos == 10'h1AA, "R9 vpos", cfg_vpos, 10'h1AA);
        send_byte(8'h15);
        chk(cfg_vpos == 10'h195, "R9 sticky command", cfg_vpos, 10'h195);
        send_byte(8'hB3);
        send_byte(8'h3F);
        chk(cfg_hpos == 10'h0FF && cfg_vpos == 10'h195, "R9 hpos", cfg_hpos, 10'h0FF);
    endtask

    task automatic t_mode();
        send_byte(8'hE5);
        send_byte(8'h00);
        chk(mode_eff == 4'h5, "R10 register only", mode_eff, 5);
        mode_pin = 4'hA;
        ticks(2);
        chk(mode_eff == 4'hF, "R10 ORed pins", mode_eff, 15);
        mode_pin = 4'h0;
        sel_hi();
    endtask

    task automatic t_idle_bits();
        send_byte(8'hA3);
        chk(cfg_vpos == 10'h195, "R2 ignored while deselected", cfg_vpos, 10'h195);
        sel_lo();
        send_bits(8'h80, 4);
        sel_hi();
        sel_lo();
        send_byte(8'h84);
        chk(addr_row == 4, "R2 partial byte dropped", addr_row, 4);
        sel_hi();
    endtask

    task automatic t_clear();
        int base = wr_cnt;
        busy_cycles = 0;
        sel_lo();
        send_byte(8'hC4);
        chk(clr_busy == 1'b1, "R11 busy", clr_busy, 1);
        sel_hi();
        sel_lo();
        send_byte(8'h90);
        send_byte(8'h22);
        sel_hi();
        while (clr_busy) ticks(1);
        ticks(2);
        chk(wr_cnt - base == 288, "R12 only clear writes", wr_cnt - base, 288);
        chk(clr_bad == 0, "R11 blank data", clr_bad, 0);
        chk(busy_cycles >= CLR_MIN, "R11 duration", busy_cycles, CLR_MIN);
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        ticks(2);
        t_reset();
        t_addr();
        t_char();
        t_lock();
        t_release();
        t_wrap();
        t_clamp();
        t_cfg();
        t_mode();
        t_idle_bits();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule